// File: doc/BRIEF.md
# Parallel-Prefix Tree Adder

This block is a purely combinational N-bit binary adder. Operand bits are first reduced to per-position generate and propagate signals. A logarithmic network of two-input combine cells then builds the group generate of every bit range that starts at the least significant end. Each of those group generates is the carry into the next bit position. A last row of XOR gates turns the carries and the per-bit propagates into the sum.

The carry-in is modelled as a generate at position -1 whose propagate is zero. It is folded into bit 0 before the tree, so the tree works on exactly N positions. Because that folded position has a group propagate of zero, every group generate the tree reports is already a finished carry.

An elaboration-time parameter picks one of three network shapes:
- dense: minimum depth, fanout of at most 2, many wires;
- sparse: an up-sweep followed by a down-sweep, with few cells and fanout 2;
- divide-and-conquer: minimum depth, with fanout that doubles at each level.

The width must be a power of two between 4 and 64. The block is placed wherever a single-cycle carry-propagate addition is needed, and the shape is chosen to trade depth, cell count and wiring.

Top module: `prefix_adder`

## Requirements
- R1: For every topology, `{cout, sum}` equals the unsigned value `a + b + cin`: `sum` carries bits WIDTH-1..0 of that total and `cout` carries bit WIDTH.
- R2: When `a ^ b` is all ones, a carry-in of 1 must travel the full width: `sum` is all zeros and `cout` is 1. A carry-in of 0 gives an all-ones `sum` and a `cout` of 0.
- R3: With `cin` = 0 and `a` = 0, `sum` equals `b` and `cout` is 0. In particular, all-zero inputs give all-zero outputs.
- R4: The three topology settings produce identical `sum` and `cout` for identical inputs. The settings are `TOPO_DENSE` (log2 WIDTH levels, fanout 2), `TOPO_SPARSE` (2*log2 WIDTH - 1 levels, fanout 2) and `TOPO_DIVIDE` (log2 WIDTH levels, fanout up to WIDTH/2).
- R5: The `WIDTH` parameter accepts any power of two from 4 to 64, and R1 holds at each such width. The bench covers 8 (exhaustively), 32 and 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
Two functions of the block can fall in the same evaluation:
- the carry-in, injected as the generate of position -1;
- a propagate run spanning the whole width, which must pass that carry through every tree level to `cout`.

Both are provoked together by operands whose XOR is all ones with `cin` set. They also occur throughout the exhaustive 8-bit sweep, which covers every propagate-run length against every carry-in value. Each case is judged twice: against a behavioural sum computed in the bench, and against the outputs of the other two topologies at the same width.

// File: rtl/prefix_adder_pkg.sv
`timescale 1ns/1ps
package prefix_adder_pkg;

    // Network shape chosen at elaboration
    typedef enum logic [1:0] {
        TOPO_DENSE  = 2'd0,
        TOPO_SPARSE = 2'd1,
        TOPO_DIVIDE = 2'd2
    } topo_e;

    // Group generate / propagate pair
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Valency-2 combine: hi covers the upper range, lo the adjacent lower one
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    function automatic bit width_ok(int w);
        return (w >= 4) && (w <= 64) && ((w & (w - 1)) == 0);
    endfunction

    // Number of combine levels for a shape
    function automatic int tree_depth(topo_e t, int w);
        int lg;
        lg = $clog2(w);
        return (t == TOPO_SPARSE) ? (2 * lg - 1) : lg;
    endfunction

    // Column that column i merges with at level lvl (1-based), or -1 to pass
    function automatic int gp_partner(topo_e t, int w, int lvl, int i);
        int lg;
        int span;
        int k;
        lg = $clog2(w);
        case (t)
            TOPO_DENSE: begin
                span = 1 << (lvl - 1);
                return (i >= span) ? (i - span) : -1;
            end
            TOPO_DIVIDE: begin
                if (((i >> (lvl - 1)) & 1) == 1)
                    return ((i >> (lvl - 1)) << (lvl - 1)) - 1;
                return -1;
            end
            default: begin
                if (lvl <= lg) begin
                    span = 1 << lvl;
                    if (((i + 1) % span) == 0)
                        return i - span / 2;
                end else begin
                    k    = 2 * lg - lvl;
                    span = 1 << k;
                    if ((((i + 1) % span) == span / 2) && (i >= span))
                        return i - span / 2;
                end
                return -1;
            end
        endcase
    endfunction

endpackage

// File: rtl/pa_bit_gp.sv
`timescale 1ns/1ps
module pa_bit_gp
    import prefix_adder_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output gp_t  [WIDTH-1:0] leaf,
    output logic [WIDTH-1:0] half_sum
);

    assign half_sum = a ^ b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_fold
            // position -1 (g = cin, p = 0) merged into bit 0
            assign leaf[0].g = (a[0] & b[0]) | (half_sum[0] & cin);
            assign leaf[0].p = 1'b0;
        end else begin : g_plain
            assign leaf[i].g = a[i] & b[i];
            assign leaf[i].p = half_sum[i];
        end
    end

endmodule

// File: rtl/pa_gp_cell.sv
`timescale 1ns/1ps
module pa_gp_cell
    import prefix_adder_pkg::*;
(
    input  gp_t hi,
    input  gp_t lo,
    output gp_t y
);

    assign y = gp_merge(hi, lo);

endmodule

// File: rtl/pa_prefix_net.sv
`timescale 1ns/1ps
module pa_prefix_net
    import prefix_adder_pkg::*;
#(
    parameter int    WIDTH = 32,
    parameter topo_e TOPO  = TOPO_DENSE
) (
    input  gp_t  [WIDTH-1:0] leaf,
    output logic [WIDTH-1:0] group_g
);

    localparam int DEPTH = tree_depth(TOPO, WIDTH);

    gp_t [WIDTH-1:0] row [DEPTH+1];
    logic            unused_top_p;

    assign row[0] = leaf;

    for (genvar l = 1; l <= DEPTH; l++) begin : g_lvl
        for (genvar i = 0; i < WIDTH; i++) begin : g_col
            localparam int J = gp_partner(TOPO, WIDTH, l, i);
            if (J >= 0) begin : g_merge
                pa_gp_cell u_cell (
                    .hi (row[l-1][i]),
                    .lo (row[l-1][J]),
                    .y  (row[l][i])
                );
            end else begin : g_pass
                assign row[l][i] = row[l-1][i];
            end
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_out
        assign group_g[i] = row[DEPTH][i].g;
    end

    // group propagates of the final row are not needed past the tree
    always_comb begin
        unused_top_p = 1'b0;
        for (int i = 0; i < WIDTH; i++)
            unused_top_p = unused_top_p ^ row[DEPTH][i].p;
    end

endmodule

// File: rtl/pa_sum.sv
`timescale 1ns/1ps
module pa_sum #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] half_sum,
    input  logic [WIDTH-1:0] group_g,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] carry;

    assign carry = {group_g, cin};
    assign sum   = half_sum ^ carry[WIDTH-1:0];
    assign cout  = carry[WIDTH];

endmodule

// File: rtl/prefix_adder.sv
`timescale 1ns/1ps
module prefix_adder
    import prefix_adder_pkg::*;
#(
    parameter int    WIDTH = 32,
    parameter topo_e TOPO  = TOPO_DENSE
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    if (!width_ok(WIDTH)) begin : g_bad_width
        $error("prefix_adder: WIDTH must be a power of two in 4..64");
    end

    gp_t  [WIDTH-1:0] leaf;
    logic [WIDTH-1:0] half_sum;
    logic [WIDTH-1:0] group_g;

    pa_bit_gp #(.WIDTH(WIDTH)) u_bit_gp (
        .a        (a),
        .b        (b),
        .cin      (cin),
        .leaf     (leaf),
        .half_sum (half_sum)
    );

    pa_prefix_net #(.WIDTH(WIDTH), .TOPO(TOPO)) u_net (
        .leaf    (leaf),
        .group_g (group_g)
    );

    pa_sum #(.WIDTH(WIDTH)) u_sum (
        .half_sum (half_sum),
        .group_g  (group_g),
        .cin      (cin),
        .sum      (sum),
        .cout     (cout)
    );

endmodule

// File: rtl/prefix_adder_chk.sv
`timescale 1ns/1ps
module prefix_adder_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);

    logic [WIDTH:0] ref_total;

    always_comb begin
        ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

        // R1
        sum_match_chk: assert ({cout, sum} == ref_total)
            else $error("sum/carry differ from a+b+cin");

        // R1
        if (a[WIDTH-1] && b[WIDTH-1]) begin
            msb_gen_chk: assert (cout)
                else $error("top-bit generate lost");
        end

        // R2
        if ((a ^ b) == {WIDTH{1'b1}}) begin
            full_prop_chk: assert ((cout == cin) && (sum == {WIDTH{~cin}}))
                else $error("full-width propagate wrong");
        end

        // R3
        if (!cin && (a == '0)) begin
            zero_cin_chk: assert ((sum == b) && !cout)
                else $error("identity addition wrong");
        end
    end

endmodule

bind prefix_adder prefix_adder_chk #(.WIDTH(WIDTH)) u_prefix_adder_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
);

// File: tb/prefix_adder_bench.sv
`timescale 1ns/1ps
module prefix_adder_bench;
    import prefix_adder_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  a8,  b8;  logic c8;
    logic [31:0] a32, b32; logic c32;
    logic [63:0] a64, b64; logic c64;

    logic [8:0]  r8  [3];
    logic [32:0] r32 [3];
    logic [64:0] r64 [3];

    for (genvar t = 0; t < 3; t++) begin : g_dut
        prefix_adder #(.WIDTH(8), .TOPO(topo_e'(t))) u_prefix_adder_w8 (
            .a(a8), .b(b8), .cin(c8), .sum(r8[t][7:0]), .cout(r8[t][8]));
        prefix_adder #(.WIDTH(32), .TOPO(topo_e'(t))) u_prefix_adder_w32 (
            .a(a32), .b(b32), .cin(c32), .sum(r32[t][31:0]), .cout(r32[t][32]));
        prefix_adder #(.WIDTH(64), .TOPO(topo_e'(t))) u_prefix_adder_w64 (
            .a(a64), .b(b64), .cin(c64), .sum(r64[t][63:0]), .cout(r64[t][64]));
    end

    task automatic chk(string tag, logic [64:0] got, logic [64:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // drive on the falling edge, compare one half period later
    task automatic apply(string tag,
                         logic [7:0] xa, logic [7:0] xb, logic xc,
                         logic [31:0] ya, logic [31:0] yb, logic yc,
                         logic [63:0] za, logic [63:0] zb, logic zc);
        logic [8:0]  e8;
        logic [32:0] e32;
        logic [64:0] e64;
        @(negedge clk);
        a8 = xa;  b8 = xb;  c8 = xc;
        a32 = ya; b32 = yb; c32 = yc;
        a64 = za; b64 = zb; c64 = zc;
        @(posedge clk);
        #1;
        e8  = 9'(xa) + 9'(xb) + 9'(xc);
        e32 = 33'(ya) + 33'(yb) + 33'(yc);
        e64 = 65'(za) + 65'(zb) + 65'(zc);
        for (int t = 0; t < 3; t++) begin
            chk($sformatf("%s/R5 w8 topo%0d", tag, t),  65'(r8[t]),  65'(e8));
            chk($sformatf("%s/R5 w32 topo%0d", tag, t), 65'(r32[t]), 65'(e32));
            chk($sformatf("%s/R5 w64 topo%0d", tag, t), r64[t],      e64);
        end
        for (int t = 1; t < 3; t++) begin
            chk($sformatf("R4 w8 topo%0d vs dense", t),  65'(r8[t]),  65'(r8[0]));
            chk($sformatf("R4 w32 topo%0d vs dense", t), 65'(r32[t]), 65'(r32[0]));
        end
    endtask

    initial begin
        a8 = '0; b8 = '0; c8 = 1'b0;
        a32 = '0; b32 = '0; c32 = 1'b0;
        a64 = '0; b64 = '0; c64 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R3: quiet inputs give quiet outputs
        apply("R3 zeros", 8'h00, 8'h00, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0);
        chk("R3 w64 zero sum", r64[2], 65'd0);

        // R2: carry-in must cross every position
        apply("R2 ones+cin", 8'hFF, 8'h00, 1'b1, '1, '0, 1'b1, '1, '0, 1'b1);
        for (int t = 0; t < 3; t++) begin
            chk($sformatf("R2 w64 topo%0d carry crosses", t), r64[t], {1'b1, 64'd0});
            chk($sformatf("R2 w8 topo%0d carry crosses", t), 65'(r8[t]), 65'h100);
        end
        apply("R2 split run", 8'h5A, 8'hA5, 1'b1, 32'h0F0F_F0F0, 32'hF0F0_0F0F, 1'b1,
              64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1);
        apply("R2 no cin", 8'h5A, 8'hA5, 1'b0, 32'h0F0F_F0F0, 32'hF0F0_0F0F, 1'b0,
              64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0);
        chk("R2 w32 no cin all ones", 65'(r32[1]), 65'h0_FFFF_FFFF);

        // R3: identity addition
        apply("R3 identity", 8'h00, 8'hC3, 1'b0, '0, 32'hDEAD_BEEF, 1'b0,
              '0, 64'h8000_0000_0000_0001, 1'b0);
        chk("R3 w32 sum is b", 65'(r32[2]), 65'h0_DEAD_BEEF);

        // R1: generates at the top, alternating kill/generate patterns
        apply("R1 top gen", 8'h80, 8'h80, 1'b0, 32'h8000_0000, 32'h8000_0000, 1'b1,
              64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1);
        apply("R1 all ones both", 8'hFF, 8'hFF, 1'b1, '1, '1, 1'b1, '1, '1, 1'b0);

        // R1, R5: exhaustive at 8 bits, random at 32 and 64 bits
        for (int x = 0; x < 131072; x++) begin
            apply("R1", x[15:8], x[7:0], x[16],
                  $urandom, $urandom, 1'($urandom),
                  {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule